// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire serial slave engine in a non-volatile memory. During a write command it takes the data bytes the engine decodes and gathers them in a 64-byte page latch. Each byte goes into the lane chosen by the low six bits of the word pointer. The pointer starts from the word address the engine loaded and steps only within the current page. A per-lane valid mask records which lanes have actually received a byte.

A STOP condition commits the gathered bytes. The write-protect input is looked at only on the STOP cycle. If write protect is low and at least one lane holds a byte, the block starts a self-timed write cycle. For the whole cycle it raises a busy flag, and during the cycle it writes each received lane, once and in ascending lane order, through a simple array write port. If write protect is high, nothing is stored and the block is ready again on the next cycle. A START condition with no STOP before it discards the bytes gathered so far. The length of the write cycle is a parameter in clock cycles.

Top module: `page_wbuf`

## Requirements
- R1: After reset, `busy_o` is 0, `mem_we_o` is 0 and `ptr_o` is 0.
- R2: An accepted data byte is stored in lane `ptr_o[5:0]`. Afterwards `ptr_o[5:0]` increases by one modulo 64 and `ptr_o[13:6]` does not change, so a command never leaves its page. A word-address load sets `ptr_o` to the loaded value.
- R3: When more than 64 bytes arrive before STOP, the lane index wraps and the last byte received for a lane is the one written.
- R4: Only STOP starts a write cycle. A START strobe clears every collected lane, so START, then bytes, then START again, then STOP writes nothing.
- R5: `wp_i` is sampled on the STOP cycle. If it is 1, no array write occurs, `busy_o` stays 0, and the lanes are cleared.
- R6: A change on `wp_i` after the STOP cycle does not alter a write cycle already started.
- R7: A committed cycle holds `busy_o` at 1 for exactly `WC_CYCLES` cycles, starting on the cycle after STOP. `mem_we_o` is asserted only while `busy_o` is 1.
- R8: A commit writes only the lanes that received a byte, each exactly once, in ascending lane order, at address {`ptr_o[13:6]`, lane}. A STOP with no lane filled starts no cycle.
- R9: While `busy_o` is 1, byte, address-load, START and STOP strobes are ignored. The pointer and the lanes are left unchanged.
- R10: After a single-byte write to address A, `ptr_o` holds the next address in the page: {A[13:6], A[5:0]+1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START condition strobe from the slave engine |
| addr_load_i | input | 1 | Word-address load strobe |
| addr_i | input | ADDR_W | Word address to load |
| byte_vld_i | input | 1 | Data byte valid strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP condition strobe |
| wp_i | input | 1 | Write-protect level, 1 blocks the commit |
| busy_o | output | 1 | High for the whole self-timed write cycle |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| ptr_o | output | ADDR_W | Current word pointer |

## Verification
The assertions check a set of properties on every cycle. Array writes happen only while busy. Busy rises only after a STOP taken with write protect low. The pointer is frozen while busy. The pointer steps only inside its page. A clear empties the mask, and busy holds until the count ends. Some behaviour only the bench scenarios can show: which data lands at which address, that the last byte wins after a wrap, that a repeated START discards pending bytes, that write protect is ignored after STOP, and the exact length of the busy window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_WRITE = 1'b1
   } pwb_phase_e;

   function automatic int unsigned lane_bits(input int unsigned depth);
      return (depth <= 1) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned LANE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] ptr_o
);

   generate
      if (LANE_W >= ADDR_W) begin : g_bad_width
         $error("pwb_ptr: lane field must be narrower than the address");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_i) begin
         ptr_q <= load_addr_i;
      end else if (step_i) begin
         ptr_q[LANE_W-1:0] <= ptr_q[LANE_W-1:0] + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

   AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (ptr_o[ADDR_W-1:LANE_W] == $past(ptr_o[ADDR_W-1:LANE_W]))); // R2

   AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (ptr_o[LANE_W-1:0] == LANE_W'($past(ptr_o[LANE_W-1:0]) + 1'b1))); // R2

endmodule

// File: rtl/pwb_latch.sv
module pwb_latch #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned LANE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [LANE_W-1:0] wr_lane_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              clr_i,
   input  logic [LANE_W-1:0] rd_lane_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_mask_o,
   output logic              any_o
);

   generate
      if (DEPTH != (1 << LANE_W)) begin : g_bad_depth
         $error("pwb_latch: depth must equal 2**LANE_W");
      end
   endgenerate

   logic [DATA_W-1:0] lane_data [DEPTH];
   logic [DEPTH-1:0]  lane_mask;

   for (genvar g = 0; g < DEPTH; g++) begin : g_lane
      logic [DATA_W-1:0] d_q;
      logic              m_q;
      logic              hit;

      assign hit = wr_i && (wr_lane_i == LANE_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            m_q <= 1'b0;
         end else begin
            if (hit) d_q <= wr_data_i;
            if (clr_i)    m_q <= 1'b0;
            else if (hit) m_q <= 1'b1;
         end
      end

      assign lane_data[g] = d_q;
      assign lane_mask[g] = m_q;
   end

   assign rd_data_o = lane_data[rd_lane_i];
   assign rd_mask_o = lane_mask[rd_lane_i];
   assign any_o     = |lane_mask;

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !any_o); // R4

endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
   import pwb_pkg::*;
#(
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned LANE_W    = 6,
   parameter int unsigned WC_CYCLES = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   output logic              busy_o,
   output logic              scan_vld_o,
   output logic [LANE_W-1:0] scan_lane_o,
   output logic              done_o
);

   localparam int unsigned CNT_W = $clog2(WC_CYCLES);

   generate
      if (WC_CYCLES <= DEPTH) begin : g_bad_cycle
         $error("pwb_commit: write cycle must be longer than the page scan");
      end
   endgenerate

   pwb_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last = (cnt_q == CNT_W'(WC_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (go_i) begin
                  phase_q <= PH_WRITE;
                  cnt_q   <= '0;
               end
            end
            PH_WRITE: begin
               if (last) phase_q <= PH_IDLE;
               else      cnt_q   <= cnt_q + 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o      = (phase_q == PH_WRITE);
   assign scan_vld_o  = busy_o && (cnt_q < CNT_W'(DEPTH));
   assign scan_lane_o = cnt_q[LANE_W-1:0];
   assign done_o      = busy_o && last;

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last) |=> busy_o); // R7

   AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R7

endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
   import pwb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 64,
   parameter int unsigned WC_CYCLES  = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              wp_i,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic [ADDR_W-1:0] ptr_o
);

   localparam int unsigned LANE_W = lane_bits(PAGE_BYTES);

   logic              byte_acc, addr_acc, start_acc, stop_acc;
   logic              go, done, any_lane, lat_clr;
   logic              scan_vld, rd_mask;
   logic [LANE_W-1:0] scan_lane;
   logic [DATA_W-1:0] rd_data;

   assign byte_acc  = byte_vld_i  && !busy_o;
   assign addr_acc  = addr_load_i && !busy_o;
   assign start_acc = start_i     && !busy_o;
   assign stop_acc  = stop_i      && !busy_o;

   assign go      = stop_acc && any_lane && !wp_i;
   assign lat_clr = start_acc || (stop_acc && !go) || done;

   pwb_ptr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (addr_acc),
      .load_addr_i (addr_i),
      .step_i      (byte_acc),
      .ptr_o       (ptr_o)
   );

   pwb_latch #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .LANE_W(LANE_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (byte_acc),
      .wr_lane_i (ptr_o[LANE_W-1:0]),
      .wr_data_i (byte_i),
      .clr_i     (lat_clr),
      .rd_lane_i (scan_lane),
      .rd_data_o (rd_data),
      .rd_mask_o (rd_mask),
      .any_o     (any_lane)
   );

   pwb_commit #(.DEPTH(PAGE_BYTES), .LANE_W(LANE_W), .WC_CYCLES(WC_CYCLES)) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go),
      .busy_o      (busy_o),
      .scan_vld_o  (scan_vld),
      .scan_lane_o (scan_lane),
      .done_o      (done)
   );

   assign mem_we_o   = scan_vld && rd_mask;
   assign mem_addr_o = {ptr_o[ADDR_W-1:LANE_W], scan_lane};
   assign mem_data_o = rd_data;

   AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o); // R7

   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i))); // R5

   AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(ptr_o)); // R9

endmodule

// File: tb/tb_page_wbuf.sv
module tb_page_wbuf;

   localparam int WC = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, addr_load_i = 1'b0, byte_vld_i = 1'b0;
   logic        stop_i = 1'b0, wp_i = 1'b0;
   logic [13:0] addr_i = '0;
   logic [7:0]  byte_i = '0;
   logic        busy_o, mem_we_o;
   logic [13:0] mem_addr_o, ptr_o;
   logic [7:0]  mem_data_o;

   int n_cmp = 0, n_bad = 0;
   int nlog  = 0;
   bit finished = 0;
   logic [13:0] log_a [256];
   logic [7:0]  log_d [256];

   always #10 clk = ~clk;

   page_wbuf #(.ADDR_W(14), .DATA_W(8), .PAGE_BYTES(64), .WC_CYCLES(WC)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
      .addr_i(addr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
      .wp_i(wp_i), .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_data_o(mem_data_o), .ptr_o(ptr_o)
   );

   always @(posedge clk) begin
      if (mem_we_o === 1'b1) begin
         log_a[nlog % 256] <= mem_addr_o;
         log_d[nlog % 256] <= mem_data_o;
         nlog <= nlog + 1;
      end
   end

   // table: start address, byte count, wp at STOP, first data value
   localparam int NV = 6;
   localparam logic [13:0] VA [NV] = '{14'h0123, 14'h2A40, 14'h107C, 14'h0305, 14'h3FFF, 14'h0200};
   localparam int          VN [NV] = '{1, 64, 6, 70, 1, 5};
   localparam logic        VW [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
   localparam logic [7:0]  VS [NV] = '{8'h11, 8'h20, 8'h40, 8'h80, 8'h05, 8'h33};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [13:0] a, input int n, input logic wp,
                          input logic [7:0] seed, input bit flip_wp, input bit stray);
      logic [7:0]  ed [64];
      bit          ev [64];
      logic [13:0] exp_ptr;
      int base, bcnt, k, nexp;
      for (int l = 0; l < 64; l++) begin ev[l] = 0; ed[l] = '0; end
      for (int i = 0; i < n; i++) begin
         ev[(a[5:0] + i) % 64] = 1;
         ed[(a[5:0] + i) % 64] = 8'(seed + i);
      end
      exp_ptr = {a[13:6], 6'(a[5:0] + n)};
      base = nlog;
      @(negedge clk) start_i = 1;
      @(negedge clk) start_i = 0; addr_load_i = 1; addr_i = a;
      @(negedge clk) addr_load_i = 0;
      for (int i = 0; i < n; i++) begin
         byte_vld_i = 1; byte_i = 8'(seed + i);
         @(negedge clk);
      end
      byte_vld_i = 0;
      chk("R2 R10 pointer after bytes", 32'(ptr_o), 32'(exp_ptr));
      wp_i = wp; stop_i = 1;
      @(negedge clk) stop_i = 0;
      if (flip_wp) wp_i = ~wp;
      bcnt = 0;
      for (int c = 0; c < WC + 8; c++) begin
         if (busy_o) bcnt++;
         if (stray && c == 3) begin
            byte_vld_i = 1; byte_i = 8'hEE; addr_load_i = 1; addr_i = 14'h0000;
         end else begin
            byte_vld_i = 0; addr_load_i = 0;
         end
         @(negedge clk);
      end
      chk("R5 R7 busy length", 32'(bcnt), (wp || n == 0) ? 32'd0 : 32'(WC));
      nexp = 0;
      if (!wp) for (int l = 0; l < 64; l++) if (ev[l]) nexp++;
      chk("R8 R5 write count", 32'(nlog - base), 32'(nexp));
      k = 0;
      if (!wp && (nlog - base) == nexp) begin
         for (int l = 0; l < 64; l++) begin
            if (ev[l]) begin
               chk("R8 write address", 32'(log_a[(base + k) % 256]), 32'({a[13:6], 6'(l)}));
               chk("R3 R8 write data", 32'(log_d[(base + k) % 256]), 32'(ed[l]));
               k++;
            end
         end
      end
      chk("R9 pointer after cycle", 32'(ptr_o), 32'(exp_ptr));
      wp_i = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int base;
      int bcnt;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy at reset", 32'(busy_o), 32'd0);
      chk("R1 we at reset", 32'(mem_we_o), 32'd0);
      chk("R1 ptr at reset", 32'(ptr_o), 32'd0);
      rst_n = 1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) run_cmd(VA[v], VN[v], VW[v], VS[v], 1'b0, 1'b0);

      // R6: wp raised right after STOP
      run_cmd(14'h1A09, 4, 1'b0, 8'hC0, 1'b1, 1'b0);

      // R9: strobes during busy are ignored
      run_cmd(14'h0A3E, 2, 1'b0, 8'h70, 1'b0, 1'b1);
      base = nlog;
      @(negedge clk) stop_i = 1;
      @(negedge clk) stop_i = 0;
      bcnt = 0;
      for (int c = 0; c < 5; c++) begin
         if (busy_o) bcnt++;
         @(negedge clk);
      end
      chk("R9 R8 no stray lane after busy", 32'(bcnt), 32'd0);
      chk("R9 no stray write", 32'(nlog - base), 32'd0);

      // R4: repeated START discards bytes
      base = nlog;
      @(negedge clk) start_i = 1;
      @(negedge clk) start_i = 0; addr_load_i = 1; addr_i = 14'h0500;
      @(negedge clk) addr_load_i = 0;
      for (int i = 0; i < 3; i++) begin
         byte_vld_i = 1; byte_i = 8'(8'hA0 + i);
         @(negedge clk);
      end
      byte_vld_i = 0;
      start_i = 1;
      @(negedge clk) start_i = 0;
      @(negedge clk) stop_i = 1;
      @(negedge clk) stop_i = 0;
      bcnt = 0;
      for (int c = 0; c < 10; c++) begin
         if (busy_o) bcnt++;
         @(negedge clk);
      end
      chk("R4 busy after repeated start", 32'(bcnt), 32'd0);
      chk("R4 writes after repeated start", 32'(nlog - base), 32'd0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule